// File: doc/BRIEF.md
# UART Receive Queue with Per-Character Error Tags and Line Status

This block is the receive side of a UART's host-facing buffering. Each character from the serial receiver goes into a 64-deep first-in first-out queue. The character is stored together with three tags: break, framing error and parity error. The host sees the oldest character on a data output. A separate 8-bit line-status word reports the tags of that oldest character, whether any tagged character remains anywhere in the queue, whether a character was lost, and the state of the transmitter.

Software reads the status word first and then the data byte, so that it knows whether the byte it is about to take is good. A running count of tagged entries drives a summary bit. That bit stays high until the last tagged character has been read out. A character that arrives while the queue is full is dropped and raises an overrun flag, which a status read clears. The two transmitter empty indications come in from the transmit side and are only passed through into the status word.

Top module: `rxq_status_top`

## Requirements
- R1: Characters leave the queue in arrival order. `head_data` shows the oldest stored byte whenever the queue is not empty. The queue holds up to DEPTH (64) characters.
- R2: `status[0]` is 1 exactly when the queue holds at least one character.
- R3: `status[4]` is the break tag, `status[3]` the framing tag and `status[2]` the parity tag of the oldest stored character. All three read 0 while the queue is empty.
- R4: `status[7]` is 1 while at least one stored character has any of its three tags set. It goes to 0 once the last such character has been read out.
- R5: A character that arrives with the break tag set is stored as 0x00, whatever value is on `rx_data`.
- R6: A character that arrives while the queue is full is discarded and sets `status[1]`. This holds even when a data read happens in the same cycle. `status[1]` clears on the cycle after a status read. A new overrun in the same cycle as the read keeps it set.
- R7: A data read while the queue is empty changes nothing. In that state `head_data` shows the last byte that was read out, or 0x00 if none has been read since reset.
- R8: When a character is written and another is read in the same cycle, the occupancy and the tagged-entry count both stay consistent with the queue contents.
- R9: `status[5]` equals `tx_hold_empty`. `status[6]` is 1 only when both `tx_hold_empty` and `tx_shift_empty` are 1.
- R10: After reset the queue is empty, the overrun flag is 0 and `head_data` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_valid | input | 1 | One-cycle strobe: a received character is present |
| rx_data | input | 8 | Received character |
| rx_brk | input | 1 | Break tag for the received character |
| rx_frm | input | 1 | Framing-error tag (no valid stop bit) |
| rx_par | input | 1 | Parity-error tag |
| host_data_rd | input | 1 | Host reads the data byte; removes the oldest entry |
| host_stat_rd | input | 1 | Host reads the status word; clears the overrun flag |
| tx_hold_empty | input | 1 | Transmit holding register or FIFO is empty |
| tx_shift_empty | input | 1 | Transmit shift register is empty |
| head_data | output | 8 | Oldest stored byte, or the last byte read out when empty |
| status | output | 8 | Line status word |

## Verification
The assertions assume that `rx_valid`, `host_data_rd` and `host_stat_rd` are single-cycle strobes sampled on the clock edge. They also assume that the tag inputs are only meaningful while `rx_valid` is high. The design itself guards against reads of an empty queue and writes to a full one, so the assertions do not depend on the host avoiding those. The stimulus drives every input on the falling edge from a random generator. It runs in phases that fill the queue past full, drain it past empty, and mix writes and reads at several densities with tagged characters and status reads scattered in. This deliberately reaches both edges and the same-cycle write/read cases.

// File: rtl/rxq_pkg.sv
// Package: shared types for the receive queue.
// Assumes an 8-bit character and three error tags per entry.
package rxq_pkg;
    localparam int CHAR_W = 8;

    typedef struct packed {
        logic              brk;
        logic              frm;
        logic              par;
        logic [CHAR_W-1:0] byte_v;
    } rxq_entry_t;
endpackage

// File: rtl/rxq_store.sv
// Module: circular storage for tagged characters with an occupancy count.
// Assumes push/pop are single-cycle strobes; it rejects a push when full
// and a pop when empty. Also keeps the last byte read out, for empty reads.
module rxq_store
    import rxq_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  rxq_entry_t       push_entry,
    input  logic             pop,
    output logic             push_ok,
    output logic             pop_ok,
    output logic             full,
    output logic [CW-1:0]    occ,
    output rxq_entry_t       head,
    output logic [CHAR_W-1:0] last_byte
);
    rxq_entry_t    mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] occ_q;

    // Accept/reject decisions from the current occupancy.
    always_comb begin
        full    = (occ_q == CW'(DEPTH));
        push_ok = push && !full;
        pop_ok  = pop && (occ_q != '0);
    end

    // Write the accepted entry into the slot at the write pointer.
    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= push_entry;
    end

    // Advance the pointers and the occupancy count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            occ_q  <= '0;
        end else begin
            if (push_ok) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (pop_ok)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            case ({push_ok, pop_ok})
                2'b10:   occ_q <= occ_q + 1'b1;
                2'b01:   occ_q <= occ_q - 1'b1;
                default: occ_q <= occ_q;
            endcase
        end
    end

    // Remember the byte most recently read out.
    always_ff @(posedge clk) begin
        if (!rst_n)      last_byte <= '0;
        else if (pop_ok) last_byte <= mem[rd_ptr].byte_v;
    end

    assign occ  = occ_q;
    assign head = mem[rd_ptr];

    // R1
    occ_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        occ_q <= CW'(DEPTH));
    // R8
    occ_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_ok && !pop_ok) |=> occ_q == $past(occ_q) + 1'b1);
    // R8
    occ_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_ok && pop_ok) |=> $stable(occ_q));
    // R7
    empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && occ_q == '0) |=> ($stable(rd_ptr) && $stable(last_byte)));
endmodule

// File: rtl/rxq_errtrack.sv
// Module: counts stored entries that carry any error tag.
// Assumes inc/dec come only from accepted pushes and pops.
module rxq_errtrack #(
    parameter int DEPTH = 64,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc,
    input  logic          dec,
    input  logic [CW-1:0] occ,
    output logic          any_err
);
    logic [CW-1:0] err_q;

    // Net up/down count of tagged entries held in the queue.
    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= '0;
        else if (inc && !dec) err_q <= err_q + 1'b1;
        else if (dec && !inc) err_q <= err_q - 1'b1;
    end

    assign any_err = (err_q != '0);

    // R4
    err_le_occ_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_q <= occ);
    // R8
    err_no_under_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec |-> err_q != '0);
endmodule

// File: rtl/rxq_linestat.sv
// Module: overrun flag and assembly of the 8-bit line status word.
// Assumes the head tags are valid only while the queue is non-empty.
module rxq_linestat (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       nonempty,
    input  logic [2:0] head_tags,
    input  logic       any_err,
    input  logic       ovr_evt,
    input  logic       stat_rd,
    input  logic       tx_hold_empty,
    input  logic       tx_shift_empty,
    output logic [7:0] status
);
    logic ovr_q;

    // Sticky overrun: a new event wins over a clearing read.
    always_ff @(posedge clk) begin
        if (!rst_n)       ovr_q <= 1'b0;
        else if (ovr_evt) ovr_q <= 1'b1;
        else if (stat_rd) ovr_q <= 1'b0;
    end

    // Pack the status word from queue and transmitter state.
    always_comb begin
        status      = '0;
        status[0]   = nonempty;
        status[1]   = ovr_q;
        status[4:2] = nonempty ? head_tags : 3'b000;
        status[5]   = tx_hold_empty;
        status[6]   = tx_hold_empty && tx_shift_empty;
        status[7]   = any_err;
    end

    // R6
    ovr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_evt |=> ovr_q);
    // R6
    ovr_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !ovr_evt) |=> !ovr_q);
    // R3
    empty_tags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !nonempty |-> status[4:2] == 3'b000);
endmodule

// File: rtl/rxq_status_top.sv
// Module: top of the tagged receive queue with line status.
// Assumes rx_* inputs describe one character while rx_valid is high, and
// host reads are single-cycle strobes.
module rxq_status_top
    import rxq_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_valid,
    input  logic [7:0] rx_data,
    input  logic       rx_brk,
    input  logic       rx_frm,
    input  logic       rx_par,
    input  logic       host_data_rd,
    input  logic       host_stat_rd,
    input  logic       tx_hold_empty,
    input  logic       tx_shift_empty,
    output logic [7:0] head_data,
    output logic [7:0] status
);
    rxq_entry_t    in_entry, head;
    logic          push_ok, pop_ok, full, any_err;
    logic [CW-1:0] occ;
    logic [7:0]    last_byte;
    logic          nonempty, in_tagged, head_tagged;

    // Form the incoming entry; a break forces the byte to zero.
    always_comb begin
        in_entry.brk    = rx_brk;
        in_entry.frm    = rx_frm;
        in_entry.par    = rx_par;
        in_entry.byte_v = rx_brk ? 8'h00 : rx_data;
        in_tagged       = rx_brk || rx_frm || rx_par;
        nonempty        = (occ != '0);
        head_tagged     = head.brk || head.frm || head.par;
        head_data       = nonempty ? head.byte_v : last_byte;
    end

    rxq_store #(.DEPTH(DEPTH)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (rx_valid),
        .push_entry(in_entry),
        .pop       (host_data_rd),
        .push_ok   (push_ok),
        .pop_ok    (pop_ok),
        .full      (full),
        .occ       (occ),
        .head      (head),
        .last_byte (last_byte)
    );

    rxq_errtrack #(.DEPTH(DEPTH)) u_err (
        .clk    (clk),
        .rst_n  (rst_n),
        .inc    (push_ok && in_tagged),
        .dec    (pop_ok && head_tagged),
        .occ    (occ),
        .any_err(any_err)
    );

    rxq_linestat u_stat (
        .clk           (clk),
        .rst_n         (rst_n),
        .nonempty      (nonempty),
        .head_tags     ({head.brk, head.frm, head.par}),
        .any_err       (any_err),
        .ovr_evt       (rx_valid && full),
        .stat_rd       (host_stat_rd),
        .tx_hold_empty (tx_hold_empty),
        .tx_shift_empty(tx_shift_empty),
        .status        (status)
    );

    // R5
    brk_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_ok && rx_brk && occ == '0) |=> head_data == 8'h00);
    // R2
    nonempty_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_ok && !pop_ok) |=> status[0]);
endmodule

// File: tb/rxq_status_top_bench.sv
module rxq_status_top_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 64;

    logic       clk = 0, rst_n = 0;
    logic       rx_valid = 0, rx_brk = 0, rx_frm = 0, rx_par = 0;
    logic [7:0] rx_data = 0;
    logic       host_data_rd = 0, host_stat_rd = 0;
    logic       tx_hold_empty = 0, tx_shift_empty = 0;
    logic [7:0] head_data, status;

    int n_cmp = 0, n_bad = 0;
    bit done = 0;

    // reference model state
    logic [10:0] q[$];
    logic [7:0]  m_last = 0;
    bit          m_ovr = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rxq_status_top #(.DEPTH(DEPTH)) u_rxq_status_top (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_brk(rx_brk), .rx_frm(rx_frm), .rx_par(rx_par),
        .host_data_rd(host_data_rd), .host_stat_rd(host_stat_rd),
        .tx_hold_empty(tx_hold_empty), .tx_shift_empty(tx_shift_empty),
        .head_data(head_data), .status(status));

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h at %0t", req, act, exp, $time);
        end
    endtask

    // Compare all outputs against the model's current state.
    task automatic compare();
        bit anyerr = 0;
        logic [7:0] eh;
        logic [2:0] et;
        foreach (q[i]) if (q[i][10:8] != 0) anyerr = 1;
        et = (q.size() > 0) ? q[0][10:8] : 3'b000;
        eh = (q.size() > 0) ? q[0][7:0] : m_last;
        if (q.size() == 0)         chk("R7 head when empty", head_data, eh);
        else if (q[0][10])         chk("R5 break byte", head_data, eh);
        else                       chk("R1 head byte", head_data, eh);
        chk("R2 nonempty bit", {7'd0, status[0]}, {7'd0, q.size() > 0});
        chk("R3 head tags", {5'd0, status[4:2]}, {5'd0, et});
        chk("R4 any-error bit", {7'd0, status[7]}, {7'd0, anyerr});
        chk("R6 overrun bit", {7'd0, status[1]}, {7'd0, m_ovr});
        chk("R9 tx bits", {6'd0, status[6:5]},
            {6'd0, tx_hold_empty & tx_shift_empty, tx_hold_empty});
    endtask

    // Update the model with the inputs applied at this edge (R8: pop then push).
    task automatic model_step();
        bit full = (q.size() == DEPTH);
        if (host_data_rd && q.size() > 0) begin
            m_last = q[0][7:0];
            void'(q.pop_front());
        end
        if (rx_valid && !full)
            q.push_back({rx_brk, rx_frm, rx_par, rx_brk ? 8'h00 : rx_data});
        if (rx_valid && full) m_ovr = 1;
        else if (host_stat_rd) m_ovr = 0;
    endtask

    // One cycle: drive at negedge, compare, then advance the model at posedge.
    task automatic cycle(int p_push, int p_pop, int p_tag, int p_stat);
        @(negedge clk);
        rx_valid       = ($urandom_range(99) < p_push);
        rx_data        = 8'($urandom);
        rx_brk         = ($urandom_range(99) < p_tag) && ($urandom_range(2) == 0);
        rx_frm         = ($urandom_range(99) < p_tag);
        rx_par         = ($urandom_range(99) < p_tag);
        host_data_rd   = ($urandom_range(99) < p_pop);
        host_stat_rd   = ($urandom_range(99) < p_stat);
        tx_hold_empty  = $urandom_range(1);
        tx_shift_empty = $urandom_range(1);
        #1 compare();
        @(posedge clk);
        model_step();
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        #1;
        // R10: reset state
        chk("R10 reset head", head_data, 8'h00);
        chk("R10 reset status", status, 8'h00);
        // R7: reads of an empty queue
        repeat (20) cycle(0, 100, 0, 20);
        // R6: fill past full with occasional reads and status reads
        repeat (150) cycle(90, 10, 30, 5);
        // drain past empty
        repeat (120) cycle(5, 90, 30, 10);
        // R8: dense simultaneous push/pop, heavy tagging
        repeat (2000) cycle(60, 60, 40, 10);
        // break-heavy, clean-heavy and sparse mixes
        repeat (1000) cycle(50, 45, 80, 20);
        repeat (1000) cycle(70, 40, 0, 5);
        repeat (1000) cycle(30, 35, 10, 30);
        repeat (200) cycle(100, 100, 50, 0);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule